// File: doc/BRIEF.md
# GPIO LED Blink Generator

This block holds two independent blink channels for general-purpose pins. Each channel has a byte-wide pin-map register that names one GPIO by set and pin, and a byte-wide control register that picks a blink rate and duty, an inverted drive level and a one-tick low-pulse mode. A shared tick counter divides the system clock down to a slow timebase. Each channel turns that tick into a waveform and then takes over the output of the pin it maps to. The override is brought out as two vectors, enable and value, with one bit per pad. Pad `(set-1)*8 + pin` is the pad for a given set and pin.

Elaboration parameters select one of two control-byte layouts. The narrow layout has a 2-bit rate code. The wide layout has a 5-bit rate/duty code whose bits are split across the byte, and it adds a per-channel option: when the active-low power-switch input stays low for longer than four seconds, the channel's pin map is erased. Software reaches the four registers through a simple byte write strobe and a combinational read port.

Top module: `gpio_blink_ctrl`

## Requirements
- R1: The registers sit at BASE_ADDR (default 0xF8) plus an offset: +0 is the channel 0 pin map, +1 the channel 0 control, +2 the channel 1 pin map and +3 the channel 1 control. A pin map stores 6 bits and reads back with bits 7:6 at zero. All registers reset to zero. Any other address reads zero, and a write to another address changes nothing.
- R2: Pin-map bits 5:3 give the set and bits 2:0 give the pin. If the set is 1..NUM_SETS, the channel sets `pad_ovr_en` bit `(set-1)*8+pin`. If the set is 0 or above NUM_SETS, the channel drives no pad.
- R3: With one tick equal to 1/TICK_HZ seconds and CLKS_PER_TICK clocks per tick, the wide layout produces these rates (period / on time): code 0 4 Hz/50%, 1 1 Hz/50%, 2 0.25 Hz/50%, 3 2 Hz/50%, 4 0.25 Hz/25%, 5 0.25 Hz/75%, 6 0.125 Hz/25%, 7 0.125 Hz/75%, 8 0.4 Hz/20%, 16 0.5 Hz/50%, 24 0.125 Hz/50%. The on phase comes first in each period.
- R4: In the wide layout, code bits 2:0 come from control bits 3:1 and code bits 4:3 come from control bits 7:6. Any code not listed in R3 blinks at 4 Hz with 50% duty.
- R5: In the narrow layout, the code is control bits 2:1 (0 = 4 Hz, 1 = 1 Hz, 2 = 0.25 Hz, 3 = 0.125 Hz, all 50%), and the pulse mode is bit 3. Bits 7:4 have no effect, so bit 4 never erases a pin map.
- R6: Control bit 0 = 1 inverts the pad value, so the on phase drives low.
- R7: In pulse mode (bit 5 in the wide layout), the pad is low for exactly one tick at the start of each period and high for the rest. Bit 0 inverts this.
- R8: A write to a channel's control register restarts that channel at the first tick of its on phase. The new phase is visible on the clock after the write.
- R9: In the wide layout, a channel with control bit 4 set has its pin map cleared once `pwr_sw_n` has been low for more than 4*TICK_HZ ticks. A shorter hold has no effect, and so does a channel with bit 4 clear.
- R10: If both channels map the same pad, channel 0 drives it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pwr_sw_n | input | 1 | Active-low power switch, synchronous to clk |
| pad_ovr_en | output | NUM_SETS*8 | Per-pad override enable |
| pad_ovr_val | output | NUM_SETS*8 | Per-pad override value |

## Verification
If a channel's phase counter wraps at the wrong count, the edge-to-edge time on the mapped pad is wrong. This shows up within one period of the selected rate, which for the slowest code is 320 ticks. If the rate or duty decode is wrong, the on and off lengths of each full period come out wrong. If the restart is wrong, the pad is in the wrong state on the very first clock after a control write. A wrong pin-map index or wrong channel precedence shows at once in the enable vector, and the hold counter is confirmed by reading the pin map back after two holds, one just under the limit and one just over it.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;

   typedef struct packed {
      logic [31:0] period;   // ticks per blink period
      logic [31:0] on_t;     // ticks in the leading on phase
   } shape_t;

   // Rate/duty code extraction for the two control-byte layouts.
   function automatic logic [4:0] code_of(input logic [7:0] ctl, input bit wide);
      return wide ? {ctl[7:6], ctl[3:1]} : {3'b000, ctl[2:1]};
   endfunction

   function automatic logic pulse_of(input logic [7:0] ctl, input bit wide);
      return wide ? ctl[5] : ctl[3];
   endfunction

   function automatic logic clr_of(input logic [7:0] ctl, input bit wide);
      return wide & ctl[4];
   endfunction

   // Period and on time in ticks, with hz ticks per second.
   function automatic shape_t shape_of(input logic [4:0] code, input bit wide,
                                       input int unsigned hz);
      shape_t s;
      s.period = hz / 4;
      s.on_t   = hz / 8;
      if (!wide) begin
         case (code[1:0])
            2'd1: begin s.period = hz;     s.on_t = hz / 2; end
            2'd2: begin s.period = 4 * hz; s.on_t = 2 * hz; end
            2'd3: begin s.period = 8 * hz; s.on_t = 4 * hz; end
            default: ;
         endcase
      end else begin
         case (code)
            5'd1:  begin s.period = hz;         s.on_t = hz / 2; end
            5'd2:  begin s.period = 4 * hz;     s.on_t = 2 * hz; end
            5'd3:  begin s.period = hz / 2;     s.on_t = hz / 4; end
            5'd4:  begin s.period = 4 * hz;     s.on_t = hz;     end
            5'd5:  begin s.period = 4 * hz;     s.on_t = 3 * hz; end
            5'd6:  begin s.period = 8 * hz;     s.on_t = 2 * hz; end
            5'd7:  begin s.period = 8 * hz;     s.on_t = 6 * hz; end
            5'd8:  begin s.period = 5 * hz / 2; s.on_t = hz / 2; end
            5'd16: begin s.period = 2 * hz;     s.on_t = hz;     end
            5'd24: begin s.period = 8 * hz;     s.on_t = 4 * hz; end
            default: ;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/gpio_blink_tick.sv
module gpio_blink_tick #(
   parameter int unsigned DIV = 2_500_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned DW = $clog2(DIV);

   logic [DW-1:0] div_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                     div_q <= '0;
      else if (div_q == DW'(DIV - 1)) div_q <= '0;
      else                            div_q <= div_q + DW'(1);
   end

   assign tick = (div_q == DW'(DIV - 1));

   // Ticks are isolated single-cycle pulses (timebase for R3).
   assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/gpio_blink_hold.sv
module gpio_blink_hold #(
   parameter int unsigned LIMIT = 160
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sw_n,
   output logic fire
);
   localparam int unsigned HW = $clog2(LIMIT + 2);

   logic [HW-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                                  held_q <= '0;
      else if (sw_n)                               held_q <= '0;
      else if (tick && (held_q <= HW'(LIMIT)))     held_q <= held_q + HW'(1);
   end

   // Fires on the tick that takes the hold past LIMIT ticks.
   assign fire = !sw_n && tick && (held_q == HW'(LIMIT));

   assert_fire_needs_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(!sw_n));
endmodule

// File: rtl/gpio_blink_chan.sv
module gpio_blink_chan
   import gpio_blink_pkg::*;
#(
   parameter int unsigned TICK_HZ = 40,
   parameter bit          WIDE    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       restart,
   input  logic [7:0] ctl,
   output logic       pad
);
   localparam int unsigned CW = $clog2(8 * TICK_HZ + 1);

   shape_t        shp;
   logic [CW-1:0] per_w;
   logic [CW-1:0] on_w;
   logic [CW-1:0] ph_q;
   logic          pulse;
   logic          inv;

   assign shp   = shape_of(code_of(ctl, WIDE), WIDE, TICK_HZ);
   assign per_w = CW'(shp.period);
   assign on_w  = CW'(shp.on_t);
   assign pulse = pulse_of(ctl, WIDE);
   assign inv   = ctl[0];

   always_ff @(posedge clk) begin
      if (!rst_n)       ph_q <= '0;
      else if (restart) ph_q <= '0;
      else if (tick)    ph_q <= (ph_q >= per_w - CW'(1)) ? '0 : ph_q + CW'(1);
   end

   assign pad = (pulse ? (ph_q != '0) : (ph_q < on_w)) ^ inv;

   assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q < per_w);

   // After a control write the first tick of the period is showing.
   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pad == (pulse ? inv : !inv)));
endmodule

// File: rtl/gpio_blink_ctrl.sv
module gpio_blink_ctrl
   import gpio_blink_pkg::*;
#(
   parameter int unsigned CLKS_PER_TICK = 2_500_000,
   parameter int unsigned TICK_HZ       = 40,
   parameter int unsigned NUM_SETS      = 5,
   parameter bit          WIDE_CODE     = 1'b1,
   parameter int unsigned BASE_ADDR     = 8'hF8,
   localparam int unsigned PADS         = NUM_SETS * 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [7:0]      reg_addr,
   input  logic [7:0]      reg_wdata,
   output logic [7:0]      reg_rdata,
   input  logic            pwr_sw_n,
   output logic [PADS-1:0] pad_ovr_en,
   output logic [PADS-1:0] pad_ovr_val
);
   localparam int unsigned NCH   = 2;
   localparam int unsigned LIMIT = 4 * TICK_HZ;

   if (NUM_SETS < 1 || NUM_SETS > 7) begin : g_bad_sets
      $error("NUM_SETS must lie in 1..7");
   end
   if (TICK_HZ == 0 || (TICK_HZ % 40) != 0) begin : g_bad_hz
      $error("TICK_HZ must be a nonzero multiple of 40");
   end
   if (CLKS_PER_TICK < 2) begin : g_bad_div
      $error("CLKS_PER_TICK must be at least 2");
   end
   if (BASE_ADDR > 252) begin : g_bad_base
      $error("BASE_ADDR leaves no room for four registers");
   end

   logic           tick;
   logic           fire;
   logic [5:0]     map_q   [NCH];
   logic [7:0]     ctl_q   [NCH];
   logic [NCH-1:0] restart;
   logic [NCH-1:0] clr_en;
   logic [NCH-1:0] map_ok;
   logic [NCH-1:0] drv;
   logic [5:0]     map_idx [NCH];

   gpio_blink_tick #(.DIV(CLKS_PER_TICK)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   gpio_blink_hold #(.LIMIT(LIMIT)) u_hold (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sw_n(pwr_sw_n), .fire(fire));

   // Register file; a hold-clear wins over a pin-map write in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            map_q[c] <= '0;
            ctl_q[c] <= '0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (fire && clr_en[c])
               map_q[c] <= '0;
            else if (reg_wr && reg_addr == 8'(BASE_ADDR + 2 * c))
               map_q[c] <= reg_wdata[5:0];
            if (reg_wr && reg_addr == 8'(BASE_ADDR + 2 * c + 1))
               ctl_q[c] <= reg_wdata;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NCH; c++) begin
         if (reg_addr == 8'(BASE_ADDR + 2 * c))     reg_rdata = {2'b00, map_q[c]};
         if (reg_addr == 8'(BASE_ADDR + 2 * c + 1)) reg_rdata = ctl_q[c];
      end
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic [2:0] set_w;

      assign set_w      = map_q[g][5:3];
      assign map_ok[g]  = (set_w != 3'd0) && (int'(set_w) <= NUM_SETS);
      assign map_idx[g] = {set_w - 3'd1, map_q[g][2:0]};
      assign restart[g] = reg_wr && (reg_addr == 8'(BASE_ADDR + 2 * g + 1));
      assign clr_en[g]  = clr_of(ctl_q[g], WIDE_CODE);

      gpio_blink_chan #(.TICK_HZ(TICK_HZ), .WIDE(WIDE_CODE)) u_chan (
         .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart[g]),
         .ctl(ctl_q[g]), .pad(drv[g]));

      assert_hold_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (fire && clr_en[g]) |=> (map_q[g] == 6'd0));
   end

   // Pad fan-out; the loop runs downward so channel 0 has the last word.
   always_comb begin
      pad_ovr_en  = '0;
      pad_ovr_val = '0;
      for (int c = NCH - 1; c >= 0; c--) begin
         if (map_ok[c]) begin
            pad_ovr_en[map_idx[c]]  = 1'b1;
            pad_ovr_val[map_idx[c]] = drv[c];
         end
      end
   end

   assert_en_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pad_ovr_en) <= NCH);

   assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (map_ok == '0) |-> (pad_ovr_en == '0));
endmodule

// File: tb/tb_gpio_blink_ctrl.sv
module tb_gpio_blink_ctrl;
   localparam int DIV  = 4;
   localparam int HZ   = 40;
   localparam int PADS = 40;
   localparam int TO   = 3000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr = 1'b0;
   logic [7:0]      reg_addr = 8'h00;
   logic [7:0]      reg_wdata = 8'h00;
   logic            pwr_sw_n = 1'b1;
   logic [7:0]      rdata, l2_rdata;
   logic [PADS-1:0] en, val, l2_en, l2_val;

   always #5 clk = ~clk;

   gpio_blink_ctrl #(.CLKS_PER_TICK(DIV), .TICK_HZ(HZ), .NUM_SETS(5), .WIDE_CODE(1'b1))
   dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .pwr_sw_n(pwr_sw_n),
        .pad_ovr_en(en), .pad_ovr_val(val));

   gpio_blink_ctrl #(.CLKS_PER_TICK(DIV), .TICK_HZ(HZ), .NUM_SETS(5), .WIDE_CODE(1'b0))
   dut_l2 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
           .reg_wdata(reg_wdata), .reg_rdata(l2_rdata), .pwr_sw_n(pwr_sw_n),
           .pad_ovr_en(l2_en), .pad_ovr_val(l2_val));

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Scoreboard items: expected on/off lengths in clocks for one pad.
   typedef struct {
      int idx;
      bit l2;
      bit act;
      int on_c;
      int off_c;
   } exp_t;

   exp_t  expq[$];
   string tagq[$];
   int    pushed = 0;
   int    done = 0;

   function automatic logic pv(input bit l2, input int idx);
      return l2 ? l2_val[idx] : val[idx];
   endfunction

   // Monitor: measures one full on phase and the following off phase.
   initial begin
      forever begin
         exp_t  e;
         string t;
         int    n;
         int    on_c;
         int    off_c;
         wait (expq.size() > 0);
         e = expq.pop_front();
         t = tagq.pop_front();
         @(negedge clk);
         n = 0;
         while (pv(e.l2, e.idx) == e.act && n < TO) begin @(negedge clk); n++; end
         n = 0;
         while (pv(e.l2, e.idx) != e.act && n < TO) begin @(negedge clk); n++; end
         on_c = 0;
         while (pv(e.l2, e.idx) == e.act && on_c < TO) begin @(negedge clk); on_c++; end
         off_c = 0;
         while (pv(e.l2, e.idx) != e.act && off_c < TO) begin @(negedge clk); off_c++; end
         chk(on_c == e.on_c, {t, " on-length"}, on_c, e.on_c);
         chk(off_c == e.off_c, {t, " off-length"}, off_c, e.off_c);
         done++;
      end
   end

   task automatic expect_wave(input int idx, input bit l2, input bit act,
                              input int on_t, input int off_t, input string tag);
      exp_t e;
      e.idx = idx; e.l2 = l2; e.act = act;
      e.on_c = on_t * DIV; e.off_c = off_t * DIV;
      expq.push_back(e);
      tagq.push_back(tag);
      pushed++;
      wait (done == pushed);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] w, output logic [7:0] w2);
      reg_addr = a;
      #1;
      w = rdata;
      w2 = l2_rdata;
   endtask

   function automatic logic [7:0] c5(input logic [4:0] code, input logic [7:0] extra);
      return {code[4:3], 2'b00, code[2:0], 1'b0} | extra;
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, r2;
      int n;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      for (int a = 8'hF8; a <= 8'hFB; a++) begin
         rd(8'(a), r, r2);
         chk(r == 8'h00, "R1 reset register", r, 0);
      end
      chk(en == '0, "R1 reset no override", en, 0);

      // R1: pin map keeps 6 bits; R2: set 7 disables
      wr(8'hF8, 8'hFF);
      rd(8'hF8, r, r2);
      chk(r == 8'h3F, "R1 pin map width", r, 8'h3F);
      chk(en == '0, "R2 set 7 unmapped", en, 0);
      wr(8'hF8, 8'h03);
      chk(en == '0, "R2 set 0 unmapped", en, 0);
      wr(8'hF8, 8'h2D);
      chk(en == (40'd1 << 37), "R2 set 5 pin 5 index", en, 40'd1 << 37);
      wr(8'hFC, 8'h55);
      rd(8'hFC, r, r2);
      chk(r == 8'h00, "R1 unused address reads zero", r, 0);
      rd(8'hF8, r, r2);
      chk(r == 8'h2D, "R1 unused write ignored", r, 8'h2D);

      // R3/R4: wide-layout rate table on set 1 pin 2 (pad 2)
      wr(8'hF8, 8'h0A);
      chk(en == 40'h4, "R2 set 1 pin 2 index", en, 40'h4);
      wr(8'hF9, c5(5'd0, 8'h00));  expect_wave(2, 0, 1, 5, 5, "R3 code0");
      wr(8'hF9, c5(5'd1, 8'h00));  expect_wave(2, 0, 1, 20, 20, "R3 code1");
      wr(8'hF9, c5(5'd2, 8'h00));  expect_wave(2, 0, 1, 80, 80, "R3 code2");
      wr(8'hF9, c5(5'd3, 8'h00));  expect_wave(2, 0, 1, 10, 10, "R3 code3");
      wr(8'hF9, c5(5'd4, 8'h00));  expect_wave(2, 0, 1, 40, 120, "R3 code4");
      wr(8'hF9, c5(5'd5, 8'h00));  expect_wave(2, 0, 1, 120, 40, "R3 code5");
      wr(8'hF9, c5(5'd6, 8'h00));  expect_wave(2, 0, 1, 80, 240, "R3 code6");
      wr(8'hF9, c5(5'd7, 8'h00));  expect_wave(2, 0, 1, 240, 80, "R3 code7");
      wr(8'hF9, c5(5'd8, 8'h00));  expect_wave(2, 0, 1, 20, 80, "R4 code8 high field");
      wr(8'hF9, c5(5'd16, 8'h00)); expect_wave(2, 0, 1, 40, 40, "R4 code16 high field");
      wr(8'hF9, c5(5'd24, 8'h00)); expect_wave(2, 0, 1, 160, 160, "R4 code24 high field");
      wr(8'hF9, c5(5'd9, 8'h00));  expect_wave(2, 0, 1, 5, 5, "R4 undefined code");

      // R6: inverted drive
      wr(8'hF9, c5(5'd3, 8'h01));  expect_wave(2, 0, 0, 10, 10, "R6 inverted");
      // R7: short low pulse, then inverted
      wr(8'hF9, c5(5'd0, 8'h20));  expect_wave(2, 0, 0, 1, 9, "R7 low pulse");
      wr(8'hF9, c5(5'd0, 8'h21));  expect_wave(2, 0, 1, 1, 9, "R7 inverted pulse");

      // R5: narrow layout on the second instance
      wr(8'hF9, 8'h06);            expect_wave(2, 1, 1, 160, 160, "R5 narrow code3");
      wr(8'hF9, 8'h04);            expect_wave(2, 1, 1, 80, 80, "R5 narrow code2");
      wr(8'hF9, 8'h08);            expect_wave(2, 1, 0, 1, 9, "R5 narrow pulse bit3");
      wr(8'hF9, 8'hC0);            expect_wave(2, 1, 1, 5, 5, "R5 narrow upper bits ignored");

      // R8: restart from the off phase
      wr(8'hF9, c5(5'd24, 8'h00));
      n = 0;
      while (val[2] != 1'b0 && n < TO) begin @(negedge clk); n++; end
      chk(val[2] == 1'b0, "R8 reached off phase", val[2], 0);
      wr(8'hF9, c5(5'd24, 8'h00));
      chk(val[2] == 1'b1, "R8 on phase right after write", val[2], 1);
      repeat (600) @(negedge clk);
      chk(val[2] == 1'b1, "R8 full on phase after restart", val[2], 1);

      // R10: both channels on pad 2, channel 0 wins
      wr(8'hFA, 8'h0A);
      wr(8'hFB, 8'h01);
      wr(8'hF9, c5(5'd24, 8'h00));
      chk(val[2] == 1'b1, "R10 channel 0 value wins", val[2], 1);
      chk(en == 40'h4, "R10 single shared pad", en, 40'h4);
      wr(8'hF8, 8'h10);
      chk(en == 40'h104, "R10 split pads", en, 40'h104);

      // R9: power-switch hold clear
      wr(8'hF9, c5(5'd24, 8'h10));
      @(negedge clk); pwr_sw_n = 1'b0;
      repeat (600) @(negedge clk);
      pwr_sw_n = 1'b1;
      @(negedge clk);
      rd(8'hF8, r, r2);
      chk(r == 8'h10, "R9 short hold keeps map", r, 8'h10);
      pwr_sw_n = 1'b0;
      repeat (700) @(negedge clk);
      pwr_sw_n = 1'b1;
      @(negedge clk);
      rd(8'hF8, r, r2);
      chk(r == 8'h00, "R9 long hold clears enabled map", r, 0);
      chk(r2 == 8'h10, "R5 narrow bit4 does not clear", r2, 8'h10);
      rd(8'hFA, r, r2);
      chk(r == 8'h0A, "R9 disabled channel keeps map", r, 8'h0A);
      chk(en == 40'h4, "R9 cleared channel releases pad", en, 40'h4);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule